// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This block divides a double-width dividend by a single-width divisor over several clock cycles. It returns a single-width quotient and remainder, or it flags a divide error. A two-bit size code selects the operand width n. At the default parameter the choices are 8, 16, 32 and 64 bits. A mode input selects unsigned or two's-complement signed arithmetic. The dividend is the pair {upper half, lower half}, each half n bits wide.

The datapath is a restoring shift-and-subtract loop that produces one quotient bit per cycle. Signed operands are first reduced to magnitudes. The quotient and remainder get their signs back in a final correction cycle, and the same cycle checks the signed range. A zero divisor, or an upper dividend half that is already at least the divisor, is caught during setup and reported at once. The block only reports faults. The surrounding core decides what to do with them.

A caller pulses `start` with its operands and waits for the one-cycle `done` pulse. On that pulse `div_err` tells whether `quo` and `rem` hold a new result.

Top module: `idiv_unit`

## Requirements
- R1: Size code k (0 to 3) selects operand width n = MAX_W >> (3-k). With MAX_W=64 the codes 0, 1, 2 and 3 give widths 8, 16, 32 and 64. The dividend is {dvd_hi[n-1:0], dvd_lo[n-1:0]} and the divisor is dsr[n-1:0]. An unsigned result places the floor quotient and the remainder in the low n bits of `quo` and `rem`, with their upper bits zero.
- R2: In unsigned mode (is_signed=0), a quotient of 2^n or more raises `div_err`.
- R3: A zero divisor raises `div_err` in either mode.
- R4: In signed mode (is_signed=1), operands are n-bit two's complement, and the dividend is the 2n-bit value. The quotient truncates toward zero. The remainder takes the dividend's sign. Both are returned as n-bit two's complement.
- R5: In signed mode, a negative quotient may reach -2^(n-1). A non-negative quotient must be below 2^(n-1). Any other quotient raises `div_err`.
- R6: A fault is found during setup when the divisor is zero, or when the magnitude of the upper dividend half is at least the divisor magnitude. Such a fault completes with `done` two clock edges after the edge that samples `start`.
- R7: Without a setup fault, `done` rises n+2 edges after the edge that samples `start`, and stays high for exactly one cycle.
- R8: While an operation is in progress, `start` is ignored. The running operation's result is unchanged and no extra `done` pulse appears.
- R9: `byte_pack` equals {rem[7:0], quo[7:0]}. For size code 0 this gives the 8-bit remainder in the upper byte and the 8-bit quotient in the lower byte.
- R10: After reset, `done`, `div_err`, `quo` and `rem` are all zero.
- R11: When `div_err` is raised, `quo` and `rem` keep the values they had before the faulting operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| size_code | input | 2 | Operand width select |
| is_signed | input | 1 | 1 = two's-complement signed division |
| dvd_hi | input | MAX_W | Upper half of the dividend |
| dvd_lo | input | MAX_W | Lower half of the dividend |
| dsr | input | MAX_W | Divisor |
| quo | output | MAX_W | Quotient, low n bits |
| rem | output | MAX_W | Remainder, low n bits |
| byte_pack | output | 16 | {rem[7:0], quo[7:0]} |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error, valid with done |

## Verification
The bench builds the divider with the default MAX_W of 64, so all four size codes are reachable. In particular, the widest size exercises the 128-bit dividend negation, where the mask wraps across the full vector. That size also exercises the immediate-overflow path with a nonzero upper half, and the -2^63 divided by -1 range fault. The 8-bit and 16-bit cases reach the signed boundary values -2^(n-1) and 2^(n-1) by hand. All cases are compared against a wide-integer reference that also predicts which faults are caught during setup, and so the expected latency.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER,
        ST_FIN
    } dstate_e;

    typedef struct packed {
        logic [1:0] size_code;
        logic       signed_op;
        logic       neg_dvd;
        logic       neg_dsr;
    } op_ctl_t;

    function automatic int unsigned width_of(input logic [1:0] code,
                                             input int unsigned max_w);
        return max_w >> (32'd3 - 32'(code));
    endfunction

endpackage

// File: rtl/idiv_prep.sv
module idiv_prep
    import idiv_pkg::*;
#(
    parameter int MAX_W = 64
) (
    input  logic [1:0]       size_code,
    input  logic             signed_op,
    input  logic [MAX_W-1:0] hi,
    input  logic [MAX_W-1:0] lo,
    input  logic [MAX_W-1:0] dsr,
    output logic [MAX_W-1:0] r_init,
    output logic [MAX_W-1:0] q_init,
    output logic [MAX_W-1:0] d_mag,
    output logic             neg_dvd,
    output logic             neg_dsr,
    output logic             zero_div,
    output logic             early_ovf
);
    localparam int DW = 2 * MAX_W;

    int unsigned      n;
    logic [MAX_W-1:0] m1;
    logic [DW-1:0]    m2;
    logic [DW-1:0]    full;
    logic [DW-1:0]    mag;
    logic [MAX_W-1:0] dv;

    always_comb begin
        n        = width_of(size_code, MAX_W);
        m1       = MAX_W'((DW'(1) << n) - DW'(1));
        m2       = (DW'(1) << (2 * n)) - DW'(1);
        full     = (DW'(hi & m1) << n) | DW'(lo & m1);
        neg_dvd  = signed_op & full[2*n-1];
        neg_dsr  = signed_op & dsr[n-1];
        mag      = neg_dvd ? ((~full + DW'(1)) & m2) : full;
        dv       = dsr & m1;
        d_mag    = neg_dsr ? ((~dv + MAX_W'(1)) & m1) : dv;
        r_init   = MAX_W'(mag >> n);
        q_init   = (MAX_W'(mag) & m1) << (MAX_W - int'(n));
        zero_div = (dv == '0);
        early_ovf = !zero_div && (r_init >= d_mag);
    end

endmodule

// File: rtl/idiv_step.sv
module idiv_step #(
    parameter int MAX_W = 64
) (
    input  logic [MAX_W-1:0] r_cur,
    input  logic [MAX_W-1:0] q_cur,
    input  logic [MAX_W-1:0] d_cur,
    output logic [MAX_W-1:0] r_nxt,
    output logic [MAX_W-1:0] q_nxt
);
    logic [MAX_W:0] trial;
    logic [MAX_W:0] diff;
    logic           qbit;

    always_comb begin
        trial = {r_cur, q_cur[MAX_W-1]};
        diff  = trial - {1'b0, d_cur};
        qbit  = (trial >= {1'b0, d_cur});
        r_nxt = qbit ? diff[MAX_W-1:0] : trial[MAX_W-1:0];
        q_nxt = {q_cur[MAX_W-2:0], qbit};
    end

endmodule

// File: rtl/idiv_fixup.sv
module idiv_fixup
    import idiv_pkg::*;
#(
    parameter int MAX_W = 64
) (
    input  op_ctl_t          ctl,
    input  logic [MAX_W-1:0] r_mag,
    input  logic [MAX_W-1:0] q_raw,
    output logic [MAX_W-1:0] quo_fix,
    output logic [MAX_W-1:0] rem_fix,
    output logic             range_err
);
    int unsigned      n;
    logic [MAX_W-1:0] m1;
    logic [MAX_W-1:0] qm;
    logic [MAX_W-1:0] half;
    logic             neg_q;

    always_comb begin
        n         = width_of(ctl.size_code, MAX_W);
        m1        = MAX_W'(({1'b0, {MAX_W{1'b1}}}) >> (MAX_W - int'(n)));
        qm        = q_raw & m1;
        half      = MAX_W'(1) << (n - 1);
        neg_q     = ctl.neg_dvd ^ ctl.neg_dsr;
        range_err = ctl.signed_op && (neg_q ? (qm > half) : (qm >= half));
        quo_fix   = neg_q ? ((~qm + MAX_W'(1)) & m1) : qm;
        rem_fix   = ctl.neg_dvd ? ((~r_mag + MAX_W'(1)) & m1) : (r_mag & m1);
    end

endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
    import idiv_pkg::*;
#(
    parameter int MAX_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       size_code,
    input  logic             is_signed,
    input  logic [MAX_W-1:0] dvd_hi,
    input  logic [MAX_W-1:0] dvd_lo,
    input  logic [MAX_W-1:0] dsr,
    output logic [MAX_W-1:0] quo,
    output logic [MAX_W-1:0] rem,
    output logic [15:0]      byte_pack,
    output logic             done,
    output logic             div_err
);
    localparam int CW = $clog2(MAX_W);

    dstate_e          state;
    op_ctl_t          ctl;
    logic [CW-1:0]    cnt;
    logic [MAX_W-1:0] hi_l, lo_l, dsr_l;
    logic [MAX_W-1:0] r_q, q_q, d_q;
    logic             fault_q;

    logic [MAX_W-1:0] r_init, q_init, d_mag;
    logic             neg_dvd, neg_dsr, zero_div, early_ovf;
    logic [MAX_W-1:0] r_nxt, q_nxt;
    logic [MAX_W-1:0] quo_fix, rem_fix;
    logic             range_err;

    idiv_prep #(.MAX_W(MAX_W)) u_prep (
        .size_code (ctl.size_code),
        .signed_op (ctl.signed_op),
        .hi        (hi_l),
        .lo        (lo_l),
        .dsr       (dsr_l),
        .r_init    (r_init),
        .q_init    (q_init),
        .d_mag     (d_mag),
        .neg_dvd   (neg_dvd),
        .neg_dsr   (neg_dsr),
        .zero_div  (zero_div),
        .early_ovf (early_ovf)
    );

    idiv_step #(.MAX_W(MAX_W)) u_step (
        .r_cur (r_q),
        .q_cur (q_q),
        .d_cur (d_q),
        .r_nxt (r_nxt),
        .q_nxt (q_nxt)
    );

    idiv_fixup #(.MAX_W(MAX_W)) u_fix (
        .ctl       (ctl),
        .r_mag     (r_q),
        .q_raw     (q_q),
        .quo_fix   (quo_fix),
        .rem_fix   (rem_fix),
        .range_err (range_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctl     <= '0;
            cnt     <= '0;
            hi_l    <= '0;
            lo_l    <= '0;
            dsr_l   <= '0;
            r_q     <= '0;
            q_q     <= '0;
            d_q     <= '0;
            fault_q <= 1'b0;
            quo     <= '0;
            rem     <= '0;
            done    <= 1'b0;
            div_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ctl.size_code <= size_code;
                        ctl.signed_op <= is_signed;
                        ctl.neg_dvd   <= 1'b0;
                        ctl.neg_dsr   <= 1'b0;
                        hi_l          <= dvd_hi;
                        lo_l          <= dvd_lo;
                        dsr_l         <= dsr;
                        state         <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    ctl.neg_dvd <= neg_dvd;
                    ctl.neg_dsr <= neg_dsr;
                    fault_q     <= zero_div | early_ovf;
                    r_q         <= r_init;
                    q_q         <= q_init;
                    d_q         <= d_mag;
                    cnt         <= CW'(width_of(ctl.size_code, MAX_W) - 1);
                    state       <= (zero_div | early_ovf) ? ST_FIN : ST_ITER;
                end
                ST_ITER: begin
                    r_q <= r_nxt;
                    q_q <= q_nxt;
                    if (cnt == '0) state <= ST_FIN;
                    else           cnt   <= cnt - CW'(1);
                end
                ST_FIN: begin
                    done <= 1'b1;
                    if (fault_q || range_err) begin
                        div_err <= 1'b1;
                    end else begin
                        div_err <= 1'b0;
                        quo     <= quo_fix;
                        rem     <= rem_fix;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign byte_pack = {rem[7:0], quo[7:0]};

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: a faulting operation leaves the results untouched
    p_fault_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (done && div_err) |-> ($stable(quo) && $stable(rem)));

    // R1: the partial remainder stays below the divisor during iteration
    p_rem_below_div_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ITER) |-> (r_q < d_q));

    // R8: a running operation is not restarted by start
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ITER) |=> (state == ST_ITER || state == ST_FIN));

    // R6: setup faults skip the iteration loop
    p_early_fast_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETUP && (zero_div || early_ovf)) |=> (state == ST_FIN));

    // R3: a zero divisor is always reported as a fault
    p_zero_fault_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETUP && zero_div) |=> fault_q);

endmodule

// File: tb/idiv_unit_tb.sv
module idiv_unit_tb;

    typedef struct packed {
        logic [1:0]  sz;
        logic        sg;
        logic [63:0] hi;
        logic [63:0] lo;
        logic [63:0] d;
        logic        err;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 64'h0,  64'h64, 64'h7,  1'b0},
        '{2'd0, 1'b0, 64'h1,  64'h00, 64'h2,  1'b0},
        '{2'd0, 1'b0, 64'h2,  64'h00, 64'h2,  1'b1},
        '{2'd0, 1'b0, 64'h0,  64'h10, 64'h0,  1'b1},
        '{2'd0, 1'b1, 64'hFF, 64'h9C, 64'h7,  1'b0},
        '{2'd0, 1'b1, 64'hFF, 64'h80, 64'h1,  1'b0},
        '{2'd0, 1'b1, 64'h00, 64'h80, 64'h1,  1'b1},
        '{2'd0, 1'b1, 64'h00, 64'h80, 64'hFF, 1'b0},
        '{2'd1, 1'b0, 64'h1,  64'h0,  64'h3,  1'b0},
        '{2'd1, 1'b1, 64'hFFFF, 64'h8000, 64'hFFFF, 1'b1},
        '{2'd2, 1'b0, 64'h12345678, 64'h9abcdef0, 64'h87654321, 1'b0},
        '{2'd2, 1'b1, 64'hFFFFFFFF, 64'h00000001, 64'h7FFFFFFF, 1'b0},
        '{2'd3, 1'b0, 64'h1, 64'h0, 64'h1, 1'b1},
        '{2'd3, 1'b0, 64'h0123456789abcdef, 64'hfedcba9876543210, 64'hffffffffffffffff, 1'b0},
        '{2'd3, 1'b1, 64'hffffffffffffffff, 64'h8000000000000000, 64'hffffffffffffffff, 1'b1},
        '{2'd3, 1'b1, 64'h0, 64'd100, 64'hfffffffffffffff9, 1'b0},
        '{2'd1, 1'b1, 64'h0, 64'h1234, 64'h0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  size_code = '0;
    logic        is_signed = 1'b0;
    logic [63:0] dvd_hi = '0, dvd_lo = '0, dsr = '0;
    logic [63:0] quo, rem;
    logic [15:0] byte_pack;
    logic        done, div_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    idiv_unit #(.MAX_W(64)) u_dut (
        .clk(clk), .rst(rst), .start(start), .size_code(size_code),
        .is_signed(is_signed), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dsr(dsr),
        .quo(quo), .rem(rem), .byte_pack(byte_pack), .done(done),
        .div_err(div_err)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [1:0] sz, input logic sg,
                                  input logic [63:0] hi, input logic [63:0] lo,
                                  input logic [63:0] d,
                                  output logic [63:0] q, output logic [63:0] r,
                                  output logic err, output logic early);
        int n;
        logic [129:0] m1, m2, num, mag, dm, qm, rm, half;
        logic sa, sb, neg;
        n    = 8 << sz;
        m1   = (130'(1) << n) - 130'(1);
        m2   = (130'(1) << (2 * n)) - 130'(1);
        num  = ((130'(hi) & m1) << n) | (130'(lo) & m1);
        dm   = 130'(d) & m1;
        sa   = sg && num[2*n-1];
        sb   = sg && dm[n-1];
        mag  = sa ? ((m2 + 130'(1) - num) & m2) : num;
        dm   = sb ? ((m1 + 130'(1) - dm) & m1) : dm;
        q = '0; r = '0;
        if (dm == '0) begin
            err = 1'b1; early = 1'b1;
            return;
        end
        qm    = mag / dm;
        rm    = mag % dm;
        early = ((mag >> n) >= dm);
        neg   = sa ^ sb;
        half  = 130'(1) << (n - 1);
        if (!sg) err = (qm > m1);
        else     err = neg ? (qm > half) : (qm >= half);
        err = err | early;
        q = 64'(neg ? ((m1 + 130'(1) - qm) & m1) : qm);
        r = 64'(sa ? ((m1 + 130'(1) - rm) & m1) : rm);
    endfunction

    // drive one operation; lat = edges after the start-sampling edge until done
    task automatic launch(input logic [1:0] sz, input logic sg, input logic [63:0] hi,
                          input logic [63:0] lo, input logic [63:0] d, output int lat);
        @(negedge clk);
        size_code = sz; is_signed = sg; dvd_hi = hi; dvd_lo = lo; dsr = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] eq, er, pq, pr;
        logic ee, early;
        int lat, exp_lat, pulses;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(done == 1'b0,    "R10 done after reset", 64'(done), 64'd0);
        chk(div_err == 1'b0, "R10 div_err after reset", 64'(div_err), 64'd0);
        chk(quo == '0,       "R10 quo after reset", quo, 64'd0);
        chk(rem == '0,       "R10 rem after reset", rem, 64'd0);

        for (int i = 0; i < NV; i++) begin
            pq = quo; pr = rem;
            model(VECS[i].sz, VECS[i].sg, VECS[i].hi, VECS[i].lo, VECS[i].d,
                  eq, er, ee, early);
            launch(VECS[i].sz, VECS[i].sg, VECS[i].hi, VECS[i].lo, VECS[i].d, lat);
            exp_lat = early ? 2 : (8 << VECS[i].sz) + 2;
            // R6 / R7: latency
            chk(lat == exp_lat, early ? "R6 setup fault latency" : "R7 result latency",
                64'(lat), 64'(exp_lat));
            // R2 / R3 / R5: fault flag (table value and model agree)
            chk(div_err == VECS[i].err && ee == VECS[i].err,
                VECS[i].d == 0 ? "R3 zero divisor fault" :
                (VECS[i].sg ? "R5 signed range fault" : "R2 unsigned overflow fault"),
                64'(div_err), 64'(VECS[i].err));
            if (VECS[i].err) begin
                // R11: results held on fault
                chk(quo == pq && rem == pr, "R11 quo/rem held on fault", quo, pq);
            end else begin
                chk(quo == eq, VECS[i].sg ? "R4 signed quotient" : "R1 unsigned quotient", quo, eq);
                chk(rem == er, VECS[i].sg ? "R4 signed remainder" : "R1 unsigned remainder", rem, er);
                if (VECS[i].sz == 2'd0)
                    chk(byte_pack == {er[7:0], eq[7:0]}, "R9 byte packing",
                        64'(byte_pack), 64'({er[7:0], eq[7:0]}));
            end
            @(negedge clk);
            chk(done == 1'b0, "R7 done lasts one cycle", 64'(done), 64'd0);
        end

        // R8: start during a run is ignored
        pulses = 0;
        @(negedge clk);
        size_code = 2'd3; is_signed = 1'b0; dvd_hi = '0; dvd_lo = 64'd1000; dsr = 64'd10;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        dsr = 64'd0; dvd_lo = 64'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 150; c++) begin
            if (done) begin
                pulses++;
                if (pulses == 1) begin
                    chk(div_err == 1'b0, "R8 busy start ignored (err)", 64'(div_err), 64'd0);
                    chk(quo == 64'd100, "R8 busy start ignored (quo)", quo, 64'd100);
                    chk(rem == 64'd0,   "R8 busy start ignored (rem)", rem, 64'd0);
                end
            end
            @(negedge clk);
        end
        chk(pulses == 1, "R8 single done pulse", 64'(pulses), 64'd1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule